// File: doc/BRIEF.md
# Multimode Counter / Bidirectional Shift Register Stage

This block is a small register stage, 4 bits wide by default, with eight operations picked by a 3-bit select on each rising clock edge. It can count up or down modulo 2^W, shift toward the top bit or toward the bottom bit, load a parallel preset, clear itself, invert every bit, or hold. A high level on the asynchronous reset clears the register at once, whatever the other inputs are.

Stages are meant to be chained with a single wire per link. The active-low trickle enable also carries the serial data for upward shifting. The active-low terminal-count output flags the end of the count while counting, and repeats the top register bit while shifting. So the terminal-count output of one stage drives the trickle-enable input of the next for both wide counting and long upward shifts. A parallel enable gates counting in all stages together. The register is available in true and inverted form.

Top module: `ctrshift_stage`

## Requirements
- R1: While `arst` is high the register reads 0 at once, without waiting for a clock edge, whatever the select and data inputs are.
- R2: Select 000 loads `preset_d` into the register at the clock edge.
- R3: Select 001 inverts every register bit at the clock edge.
- R4: Select 101 sets the register to 0 at the clock edge.
- R5: Select 111 leaves the register unchanged.
- R6: Select 110 counts up by one when both `cen_par_n` and `cen_trk_n` are low, and wraps from all ones to 0.
- R7: Select 100 counts down by one when both enables are low, and wraps from 0 to all ones.
- R8: In either count mode, a high level on either enable leaves the register unchanged.
- R9: Select 010 shifts toward the top bit: bit 0 takes `cen_trk_n` and bit i takes the old bit i-1. Neither enable gates the shift.
- R10: Select 011 shifts toward bit 0: the top bit takes `ser_dn_in` and bit i takes the old bit i+1.
- R11: `tc_n` is low in count-up mode only when the register is all ones and `cen_trk_n` is low, and in count-down mode only when the register is 0 and `cen_trk_n` is low. `cen_par_n` has no effect on `tc_n`.
- R12: In both shift modes `tc_n` equals the top register bit. In load, complement, clear and hold it is high.
- R13: `q_n` is always the bitwise inverse of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous clear, active high |
| mode_sel | input | 3 | Operation select |
| cen_par_n | input | 1 | Parallel count enable, active low |
| cen_trk_n | input | 1 | Trickle count enable, active low; serial input for upward shift |
| ser_dn_in | input | 1 | Serial input for downward shift |
| preset_d | input | W | Parallel preset data |
| q | output | W | Register contents |
| q_n | output | W | Inverted register contents |
| tc_n | output | 1 | Terminal count, active low; top bit while shifting |

## Verification
The bench drives the count from all ones into an up step and from 0 into a down step. A stage with the wrong modulus or no wrap would show a value outside the expected one after the edge. It holds one enable high at a time in both count modes to catch a stage that counts or flags terminal count on a single enable, or that lets the parallel enable reach `tc_n`. It shifts patterns in both directions while toggling both enables, which exposes an inverted shift direction, a wrong serial source or gating by the enables. Reset is raised in the middle of a clock period, so a synchronous clear shows up as a stale value.

// File: rtl/ctrshift_pkg.sv
package ctrshift_pkg;
  typedef enum logic [2:0] {
    MODE_LOAD = 3'b000,
    MODE_CMPL = 3'b001,
    MODE_SHUP = 3'b010,
    MODE_SHDN = 3'b011,
    MODE_CDN  = 3'b100,
    MODE_CLR  = 3'b101,
    MODE_CUP  = 3'b110,
    MODE_HOLD = 3'b111
  } mode_e;
endpackage

// File: rtl/ctrshift_next.sv
module ctrshift_next
  import ctrshift_pkg::*;
#(
  parameter int W = 4
) (
  input  mode_e          mode,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   preset,
  input  logic           par_n,
  input  logic           trk_n,
  input  logic           ser_dn,
  output logic [W-1:0]   nxt,
  output logic           cnt_adv
);
  function automatic logic [W-1:0] f_inc(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  function automatic logic [W-1:0] f_dec(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  function automatic logic [W-1:0] f_shift_up(input logic [W-1:0] v, input logic sin);
    return {v[W-2:0], sin};
  endfunction

  function automatic logic [W-1:0] f_shift_dn(input logic [W-1:0] v, input logic sin);
    return {sin, v[W-1:1]};
  endfunction

  logic both_en;
  assign both_en = ~par_n & ~trk_n;
  assign cnt_adv = both_en & ((mode == MODE_CUP) | (mode == MODE_CDN));

  always_comb begin
    nxt = cur;
    unique case (mode)
      MODE_LOAD: nxt = preset;
      MODE_CMPL: nxt = ~cur;
      MODE_SHUP: nxt = f_shift_up(cur, trk_n);
      MODE_SHDN: nxt = f_shift_dn(cur, ser_dn);
      MODE_CDN:  nxt = both_en ? f_dec(cur) : cur;
      MODE_CLR:  nxt = '0;
      MODE_CUP:  nxt = both_en ? f_inc(cur) : cur;
      MODE_HOLD: nxt = cur;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctrshift_tc.sv
module ctrshift_tc
  import ctrshift_pkg::*;
#(
  parameter int W = 4
) (
  input  mode_e        mode,
  input  logic [W-1:0] cur,
  input  logic         trk_n,
  output logic         tc_n
);
  logic at_top, at_bot;
  assign at_top = &cur;
  assign at_bot = ~|cur;

  always_comb begin
    unique case (mode)
      MODE_CUP:             tc_n = ~(at_top & ~trk_n);
      MODE_CDN:             tc_n = ~(at_bot & ~trk_n);
      MODE_SHUP, MODE_SHDN: tc_n = cur[W-1];
      default:              tc_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/ctrshift_stage.sv
module ctrshift_stage
  import ctrshift_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [2:0]   mode_sel,
  input  logic         cen_par_n,
  input  logic         cen_trk_n,
  input  logic         ser_dn_in,
  input  logic [W-1:0] preset_d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_n,
  output logic         tc_n
);
  mode_e        mode;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         cnt_adv;

  assign mode = mode_e'(mode_sel);

  ctrshift_next #(.W(W)) next_i (
    .mode    (mode),
    .cur     (state_q),
    .preset  (preset_d),
    .par_n   (cen_par_n),
    .trk_n   (cen_trk_n),
    .ser_dn  (ser_dn_in),
    .nxt     (state_d),
    .cnt_adv (cnt_adv)
  );

  ctrshift_tc #(.W(W)) tc_i (
    .mode  (mode),
    .cur   (state_q),
    .trk_n (cen_trk_n),
    .tc_n  (tc_n)
  );

  always_ff @(posedge clk or posedge arst) begin
    if (arst) state_q <= '0;
    else      state_q <= state_d;
  end

  assign q   = state_q;
  assign q_n = ~state_q;
endmodule

// File: rtl/ctrshift_stage_chk.sv
module ctrshift_stage_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         arst,
  input logic [2:0]   mode_sel,
  input logic         cen_par_n,
  input logic         cen_trk_n,
  input logic         ser_dn_in,
  input logic [W-1:0] preset_d,
  input logic [W-1:0] q,
  input logic         tc_n,
  input logic         cnt_adv
);
  logic is_cnt;
  assign is_cnt = (mode_sel == 3'b110) || (mode_sel == 3'b100);

  p_arst_clear_r1: assert property (@(posedge clk) arst |-> (q == '0));
  p_load_r2: assert property (@(posedge clk) disable iff (arst)
    (mode_sel == 3'b000) |=> (q == $past(preset_d)));
  p_cmpl_r3: assert property (@(posedge clk) disable iff (arst)
    (mode_sel == 3'b001) |=> (q == ~$past(q)));
  p_clr_r4: assert property (@(posedge clk) disable iff (arst)
    (mode_sel == 3'b101) |=> (q == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (arst)
    (mode_sel == 3'b111) |=> $stable(q));
  p_cup_r6: assert property (@(posedge clk) disable iff (arst)
    (mode_sel == 3'b110 && !cen_par_n && !cen_trk_n) |=> (q == W'($past(q) + W'(1))));
  p_cdn_r7: assert property (@(posedge clk) disable iff (arst)
    (mode_sel == 3'b100 && !cen_par_n && !cen_trk_n) |=> (q == W'($past(q) - W'(1))));
  p_gate_r8: assert property (@(posedge clk) disable iff (arst)
    (is_cnt && (cen_par_n || cen_trk_n)) |=> $stable(q));
  p_gate_adv_r8: assert property (@(posedge clk) disable iff (arst)
    cnt_adv |-> (is_cnt && !cen_par_n && !cen_trk_n));
  p_shup_r9: assert property (@(posedge clk) disable iff (arst)
    (mode_sel == 3'b010) |=> (q == {$past(q[W-2:0]), $past(cen_trk_n)}));
  p_shdn_r10: assert property (@(posedge clk) disable iff (arst)
    (mode_sel == 3'b011) |=> (q == {$past(ser_dn_in), $past(q[W-1:1])}));
  p_tc_trk_r11: assert property (@(posedge clk) disable iff (arst)
    (is_cnt && cen_trk_n) |-> tc_n);
  p_tc_shift_r12: assert property (@(posedge clk) disable iff (arst)
    (mode_sel[2:1] == 2'b01) |-> (tc_n == q[W-1]));
endmodule

bind ctrshift_stage ctrshift_stage_chk #(.W(W)) chk_i (
  .clk       (clk),
  .arst      (arst),
  .mode_sel  (mode_sel),
  .cen_par_n (cen_par_n),
  .cen_trk_n (cen_trk_n),
  .ser_dn_in (ser_dn_in),
  .preset_d  (preset_d),
  .q         (q),
  .tc_n      (tc_n),
  .cnt_adv   (cnt_adv)
);

// File: tb/ctrshift_stage_tb.sv
`timescale 1ns/1ps
module ctrshift_stage_tb_top;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         arst = 1'b1;
  logic [2:0]   mode_sel = 3'b111;
  logic         cen_par_n = 1'b1;
  logic         cen_trk_n = 1'b1;
  logic         ser_dn_in = 1'b0;
  logic [W-1:0] preset_d = '0;
  logic [W-1:0] q, q_n;
  logic         tc_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int exp_q = 0;

  always #10 clk = ~clk;

  ctrshift_stage #(.W(W)) dut_i (
    .clk(clk), .arst(arst), .mode_sel(mode_sel), .cen_par_n(cen_par_n),
    .cen_trk_n(cen_trk_n), .ser_dn_in(ser_dn_in), .preset_d(preset_d),
    .q(q), .q_n(q_n), .tc_n(tc_n)
  );

  function automatic string req_of(input logic [2:0] m, input logic p, input logic t);
    case (m)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R9";
      3'b011: return "R10";
      3'b101: return "R4";
      3'b111: return "R5";
      3'b110: return (!p && !t) ? "R6" : "R8";
      default: return (!p && !t) ? "R7" : "R8";
    endcase
  endfunction

  function automatic int model_next(input int cur, input logic [2:0] m, input logic p,
                                    input logic t, input logic sd, input int pre);
    bit go;
    go = (p == 1'b0) && (t == 1'b0);
    case (m)
      3'b000: return pre;
      3'b001: return MAXV - cur;
      3'b010: return ((cur * 2) % (MAXV + 1)) + int'(t);
      3'b011: return (cur / 2) + (sd ? (MAXV + 1) / 2 : 0);
      3'b100: return go ? ((cur == 0) ? MAXV : cur - 1) : cur;
      3'b101: return 0;
      3'b110: return go ? ((cur == MAXV) ? 0 : cur + 1) : cur;
      default: return cur;
    endcase
  endfunction

  function automatic bit model_tc(input int cur, input logic [2:0] m, input logic t);
    if (m == 3'b110) return !((cur == MAXV) && !t);
    if (m == 3'b100) return !((cur == 0) && !t);
    if (m == 3'b010 || m == 3'b011) return cur >= (MAXV + 1) / 2;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: check register against model, apply inputs, check tc_n,
  // then let one rising edge happen and update the model.
  task automatic step(input logic [2:0] m, input logic p, input logic t,
                      input logic sd, input logic [W-1:0] pre);
    check(int'(q) == exp_q, "reg", int'(q), exp_q);
    check(q_n == ~q, "R13", int'(q_n), MAXV - int'(q));
    mode_sel = m; cen_par_n = p; cen_trk_n = t; ser_dn_in = sd; preset_d = pre;
    #2;
    check(tc_n == model_tc(exp_q, m, t), (m[2:1] == 2'b01) ? "R12" : "R11",
          int'(tc_n), int'(model_tc(exp_q, m, t)));
    @(posedge clk);
    exp_q = model_next(exp_q, m, p, t, sd, int'(pre));
    @(negedge clk);
    check(int'(q) == exp_q, req_of(m, p, t), int'(q), exp_q);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #5;
    check(q == '0, "R1", int'(q), 0);
    @(negedge clk); @(negedge clk);
    arst = 1'b0;
    exp_q = 0;

    // R2 load, then R6 wrap from all ones to 0
    step(3'b000, 1, 1, 0, 4'hF);
    step(3'b110, 0, 0, 0, 4'h0);
    // R7 wrap from 0 to all ones
    step(3'b100, 0, 0, 0, 4'h0);
    // R8: each enable alone holds the count; R11 parallel enable does not affect tc
    step(3'b100, 1, 0, 0, 4'h0);
    step(3'b100, 0, 1, 0, 4'h0);
    step(3'b000, 1, 1, 0, 4'h0);
    step(3'b100, 1, 0, 0, 4'h0);
    step(3'b110, 0, 1, 0, 4'h0);
    // R3 complement, R4 clear, R5 hold
    step(3'b000, 1, 1, 0, 4'h5);
    step(3'b001, 0, 0, 0, 4'h0);
    step(3'b111, 0, 0, 1, 4'h3);
    step(3'b101, 1, 1, 1, 4'hF);
    // R9 / R10 shifts with enables in both states
    step(3'b010, 0, 1, 0, 4'h0);
    step(3'b010, 1, 0, 1, 4'h0);
    step(3'b010, 0, 1, 0, 4'h0);
    step(3'b011, 0, 0, 1, 4'h0);
    step(3'b011, 1, 1, 0, 4'h0);

    for (int i = 0; i < 400; i++) begin
      step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), W'($urandom_range(0, MAXV)));
    end

    // R1: asynchronous clear in the middle of a clock period
    step(3'b000, 1, 1, 0, 4'hA);
    mode_sel = 3'b110; cen_par_n = 0; cen_trk_n = 0;
    #3 arst = 1'b1;
    #1 check(q == '0, "R1", int'(q), 0);
    @(posedge clk); #1;
    check(q == '0, "R1", int'(q), 0);
    @(negedge clk);
    arst = 1'b0;
    exp_q = 0;
    step(3'b110, 0, 0, 0, 4'h0);
    step(3'b111, 1, 1, 0, 4'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule